// File: doc/BRIEF.md
# SIMD Leading-Bit Position Counter

This combinational unit takes a 64-bit operand and splits it into equal SIMD lanes of 8, 16, 32 or 64 bits. In each lane it finds the highest bit that equals a chosen polarity and reports where that bit is. The result is a count that starts at 1 for the lane's least significant bit. A count of 0 means that no bit in the lane matched. Each count is written back into its own lane of the result, with zeros above it.

An execution stage drives the operand, a lane-size code and an operation code, and takes the result in the same cycle. The block has no clock and no state. The lane-size code is thermometer coded: each bit that is set doubles the lane width. The lowest operation bit picks whether the unit searches for ones or for zeros.

Top module: `msbpos_unit`

## Requirements
- R1: With mode_i = 3'b101 (ones search), each lane's result is 1 plus the offset, from the lane's least significant bit, of the highest bit in that lane of a_i that is 1.
- R2: With mode_i = 3'b100 (zeros search), each lane's result is 1 plus the offset of the highest bit in that lane of a_i that is 0.
- R3: A lane with no matching bit returns 0. A lane in which every bit matches returns the lane width (8, 16, 32 or 64).
- R4: simd_i sets the lane width: 3'b000 gives 8 bits, 3'b001 gives 16, 3'b011 gives 32 and 3'b111 gives 64. Lanes are evaluated independently of each other.
- R5: For any simd_i code, the lane width is 8 shifted left by the number of consecutive ones counted up from simd_i[0]. For example, 3'b010 and 3'b110 give 8 bits, and 3'b101 gives 16.
- R6: Each count sits in the low bits of its lane, and the lane bits above the count read zero. In 8-bit lanes the count never exceeds 8.
- R7: A lane's result does not depend on any bit below the found position.
- R8: When mode_i[2:1] is not 2'b10, y_o is all zeros.
- R9: y_o follows the inputs combinationally, with no clock or stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 64 | Operand to be searched lane by lane |
| simd_i | input | 3 | Thermometer lane-width code |
| mode_i | input | 3 | Operation code; bit 0 selects the polarity searched for |
| y_o | output | 64 | Per-lane 1-based position, zero-extended within each lane |

## Verification
For every input the assertions check four things. A found count points at a matching bit, and no matching bit lies above it. A merged count is nonzero exactly when a match was found, and it never exceeds the width of its lane. In 8-bit lanes the result stays at or below 8. Only the bench's scenarios can show that the right lane width is chosen for each code, including the codes that are not thermometer shaped. The same holds for the polarity selection, for the zero result outside the search operation, and for the result staying the same when the bits below the found position change.

// File: rtl/msbpos_pkg.sv
package msbpos_pkg;

  localparam int unsigned DEF_SEG_W  = 8;
  localparam int unsigned DEF_LEVELS = 4;
  localparam logic [1:0]  OPC_LEAD   = 2'b10;

  // number of consecutive set bits counted upward from bit 0
  function automatic int unsigned thermo_level(input logic [7:0] code,
                                               input int unsigned nbits);
    int unsigned n;
    n = 0;
    for (int unsigned i = 0; i < nbits; i++) begin
      if (code[i] && (n == i)) n = i + 1;
    end
    return n;
  endfunction

  // count after joining two halves of HALF bits each
  function automatic int unsigned join_count(input logic hi_found,
                                             input int unsigned hi_cnt,
                                             input int unsigned lo_cnt,
                                             input int unsigned half);
    return hi_found ? (hi_cnt + half) : lo_cnt;
  endfunction

endpackage

// File: rtl/msbpos_seg.sv
module msbpos_seg #(
  parameter int unsigned W  = 8,
  parameter int unsigned CW = 7
) (
  input  logic [W-1:0]  bits_i,
  output logic          found_o,
  output logic [CW-1:0] cnt_o
);

  always_comb begin
    found_o = 1'b0;
    cnt_o   = '0;
    for (int unsigned i = 0; i < W; i++) begin
      if (bits_i[i]) begin
        found_o = 1'b1;
        cnt_o   = CW'(i + 1);
      end
    end
  end

  // the reported bit matches, and no matching bit lies above it
  always_comb begin
    if (found_o) begin
      assert_hit_matches_R1 : assert (bits_i[cnt_o - 1'b1] == 1'b1);
      assert_none_above_R7  : assert ((bits_i >> cnt_o) == '0);
    end
  end

endmodule

// File: rtl/msbpos_merge.sv
module msbpos_merge
  import msbpos_pkg::*;
#(
  parameter int unsigned HALF = 8,
  parameter int unsigned CW   = 7
) (
  input  logic          hi_found_i,
  input  logic [CW-1:0] hi_cnt_i,
  input  logic          lo_found_i,
  input  logic [CW-1:0] lo_cnt_i,
  output logic          found_o,
  output logic [CW-1:0] cnt_o
);

  assign found_o = hi_found_i | lo_found_i;
  assign cnt_o   = CW'(join_count(hi_found_i, int'(hi_cnt_i), int'(lo_cnt_i), HALF));

  always_comb begin
    assert_cnt_bound_R3  : assert (int'(cnt_o) <= 2 * HALF);
    assert_found_nz_R3   : assert (found_o == (cnt_o != '0));
  end

endmodule

// File: rtl/msbpos_pack.sv
module msbpos_pack #(
  parameter int unsigned SEG_W  = 8,
  parameter int unsigned LEVELS = 4,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SEGS   = 8,
  parameter int unsigned CW     = 7,
  parameter int unsigned LVL_W  = 2
) (
  input  logic [LEVELS-1:0][SEGS-1:0][CW-1:0] cnt_i,
  input  logic [LVL_W-1:0]                    lvl_i,
  input  logic                                en_i,
  output logic [DATA_W-1:0]                   y_o
);

  logic [LEVELS-1:0][DATA_W-1:0] lvl_y;

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
    localparam int unsigned LW  = SEG_W << lv;
    localparam int unsigned LCW = $clog2(LW) + 1;
    for (genvar s = 0; s < (SEGS >> lv); s++) begin : g_lane
      assign lvl_y[lv][s*LW +: LW] = LW'(cnt_i[lv][s][LCW-1:0]);
    end
  end

  assign y_o = en_i ? lvl_y[lvl_i] : '0;

endmodule

// File: rtl/msbpos_unit.sv
module msbpos_unit
  import msbpos_pkg::*;
#(
  parameter int unsigned SEG_W  = DEF_SEG_W,
  parameter int unsigned LEVELS = DEF_LEVELS,
  parameter int unsigned DATA_W = SEG_W << (LEVELS - 1)
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [LEVELS-2:0] simd_i,
  input  logic [2:0]        mode_i,
  output logic [DATA_W-1:0] y_o
);

  localparam int unsigned SEGS  = DATA_W / SEG_W;
  localparam int unsigned CNT_W = $clog2(DATA_W) + 1;
  localparam int unsigned LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;

  logic                               polarity;
  logic                               lead_op;
  logic [DATA_W-1:0]                  match_vec;
  logic [LVL_W-1:0]                   lane_lvl;
  logic [LEVELS-1:0][SEGS-1:0]        fnd;
  logic [LEVELS-1:0][SEGS-1:0][CNT_W-1:0] cnt;

  assign polarity  = mode_i[0];
  assign lead_op   = (mode_i[2:1] == OPC_LEAD);
  assign match_vec = polarity ? a_i : ~a_i;
  assign lane_lvl  = LVL_W'(thermo_level(8'(simd_i), LEVELS - 1));

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    msbpos_seg #(.W(SEG_W), .CW(CNT_W)) u_seg (
      .bits_i (match_vec[s*SEG_W +: SEG_W]),
      .found_o(fnd[0][s]),
      .cnt_o  (cnt[0][s])
    );
  end

  for (genvar lv = 1; lv < LEVELS; lv++) begin : g_tree
    for (genvar s = 0; s < SEGS; s++) begin : g_node
      if (s < (SEGS >> lv)) begin : g_used
        msbpos_merge #(.HALF(SEG_W << (lv - 1)), .CW(CNT_W)) u_merge (
          .hi_found_i(fnd[lv-1][2*s+1]),
          .hi_cnt_i  (cnt[lv-1][2*s+1]),
          .lo_found_i(fnd[lv-1][2*s]),
          .lo_cnt_i  (cnt[lv-1][2*s]),
          .found_o   (fnd[lv][s]),
          .cnt_o     (cnt[lv][s])
        );
      end else begin : g_idle
        assign fnd[lv][s] = 1'b0;
        assign cnt[lv][s] = '0;
      end
    end
  end

  msbpos_pack #(
    .SEG_W(SEG_W), .LEVELS(LEVELS), .DATA_W(DATA_W),
    .SEGS(SEGS), .CW(CNT_W), .LVL_W(LVL_W)
  ) u_pack (
    .cnt_i(cnt),
    .lvl_i(lane_lvl),
    .en_i (lead_op),
    .y_o  (y_o)
  );

  // byte-lane results stay within range
  always_comb begin
    if (lead_op && (lane_lvl == '0)) begin
      for (int unsigned s = 0; s < SEGS; s++) begin
        assert_byte_range_R6 : assert (y_o[s*SEG_W +: SEG_W] <= SEG_W);
      end
    end
  end

endmodule

// File: tb/msbpos_unit_tb.sv
module msbpos_unit_tb_top;

  typedef struct packed {
    logic [63:0] a;
    logic [2:0]  simd;
    logic [2:0]  mode;
    logic [63:0] y;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{64'h0,                    3'b000, 3'b101, 64'h0},                    // R3
    '{64'hFFFF_FFFF_FFFF_FFFF,  3'b111, 3'b101, 64'h40},                   // R3 R1
    '{64'hFFFF_FFFF_FFFF_FFFF,  3'b000, 3'b101, 64'h0808_0808_0808_0808},  // R3 R4
    '{64'h0,                    3'b000, 3'b100, 64'h0808_0808_0808_0808},  // R2
    '{64'h8000_0000_0000_0001,  3'b000, 3'b101, 64'h0800_0000_0000_0001},  // R1 R4
    '{64'h8000_0000_0000_0001,  3'b111, 3'b101, 64'h40},                   // R4
    '{64'h0000_0001_0000_0000,  3'b011, 3'b101, 64'h0000_0001_0000_0000},  // R4 R6
    '{64'h0010_0000_00FF_0003,  3'b001, 3'b101, 64'h0005_0000_0008_0002},  // R1 R4
    '{64'hFFFF_FFFF_FFFF_FFFE,  3'b111, 3'b100, 64'h1},                    // R2
    '{64'hFFFF_FFFF_FFFF_FFFF,  3'b111, 3'b000, 64'h0},                    // R8
    '{64'hFFFF_FFFF_FFFF_FFFF,  3'b111, 3'b111, 64'h0},                    // R8
    '{64'hFFFF_FFFF_FFFF_FFFF,  3'b010, 3'b101, 64'h0808_0808_0808_0808},  // R5
    '{64'hFFFF_FFFF_FFFF_FFFF,  3'b101, 3'b101, 64'h0010_0010_0010_0010},  // R5
    '{64'h7F00_FFFF_0000_0000,  3'b011, 3'b100, 64'h0000_0020_0000_0020},  // R2
    '{64'hFFFF_FFFF_FFFF_FFFF,  3'b110, 3'b101, 64'h0808_0808_0808_0808}   // R5
  };

  logic        clk = 1'b0;
  logic [63:0] a;
  logic [2:0]  simd;
  logic [2:0]  mode;
  logic [63:0] y;
  int          checks = 0;
  int          errors = 0;
  bit          done   = 1'b0;

  always #10 clk = ~clk;

  msbpos_unit dut_i (
    .a_i   (a),
    .simd_i(simd),
    .mode_i(mode),
    .y_o   (y)
  );

  function automatic logic [63:0] model(input logic [63:0] av,
                                        input logic [2:0]  sv,
                                        input logic [2:0]  mv);
    int          g;
    int          w;
    logic [63:0] r;
    bit          hit;
    g = 0;
    if (sv[0]) begin
      g = 1;
      if (sv[1]) begin
        g = 2;
        if (sv[2]) g = 3;
      end
    end
    w = 8 << g;
    r = '0;
    if (mv[2:1] != 2'b10) return r;
    for (int base = 0; base < 64; base += w) begin
      hit = 1'b0;
      for (int k = w - 1; k >= 0; k--) begin
        if (!hit && (av[base + k] == mv[0])) begin
          hit = 1'b1;
          r   = r | (64'(k + 1) << base);
        end
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] exp);
    checks++;
    if (y !== exp) begin
      errors++;
      $display("FAIL %s: y=%h expected=%h (a=%h simd=%b mode=%b)",
               tag, y, exp, a, simd, mode);
    end
  endtask

  task automatic apply(input logic [63:0] av, input logic [2:0] sv,
                       input logic [2:0] mv);
    @(posedge clk);
    a = av; simd = sv; mode = mv;
    @(negedge clk);
  endtask

  initial begin
    logic [63:0] base_a;
    logic [63:0] exp0;
    a = '0; simd = 3'b000; mode = 3'b000;
    @(negedge clk);
    check("R8 idle state", 64'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].a, VECS[i].simd, VECS[i].mode);
      check($sformatf("R1/R2/R4 table %0d", i), VECS[i].y);
    end

    // R9: the output follows a change within the same cycle
    apply(64'h0, 3'b111, 3'b101);
    a = 64'h0000_0000_0000_0100;
    #1;
    check("R9 same-cycle response", 64'h9);

    // R7: bits below the top match do not move the result
    for (int p = 0; p < 64; p += 7) begin
      base_a = 64'h1 << p;
      for (int t = 0; t < 4; t++) begin
        apply(base_a | ({$urandom, $urandom} & ((64'h1 << p) - 64'h1)),
              3'b111, 3'b101);
        check("R7 lower bits ignored", 64'(p + 1));
      end
    end

    // R2 with R7: zeros search, upper ones, random lower part
    exp0 = 64'h0000_0000_0000_0000;
    for (int t = 0; t < 8; t++) begin
      apply({16'hFFFF, 1'b0, 15'($urandom), 32'($urandom)}, 3'b111, 3'b100);
      check("R2 zeros search 64-bit", 64'd48);
    end

    // R4 R5 R1 R2 R8: random sweep against the bench model
    for (int t = 0; t < 600; t++) begin
      logic [63:0] ra;
      logic [2:0]  rs;
      logic [2:0]  rm;
      ra = {$urandom, $urandom};
      case ($urandom % 4)
        0: ra = ra & {$urandom, $urandom} & {$urandom, $urandom};
        1: ra = ra | {$urandom, $urandom} | {$urandom, $urandom};
        default: ;
      endcase
      rs = 3'($urandom);
      rm = (t % 5 == 0) ? 3'($urandom) : {2'b10, 1'($urandom)};
      apply(ra, rs, rm);
      check("R4/R5 random sweep", model(ra, rs, rm));
    end

    // R6: per-lane zero extension in 32-bit lanes
    apply(64'h8000_0000_8000_0000, 3'b011, 3'b101);
    check("R6 zero-extended lanes", 64'h0000_0020_0000_0020);
    apply(exp0, 3'b001, 3'b101);
    check("R3 empty 16-bit lanes", 64'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule